// File: doc/BRIEF.md
# SECDED Codec with Stuck-Word Detection

This block protects a 32-bit data word with 7 check bits, forming a 39-bit codeword for storage. The encoder half turns a data word into a codeword. The checker half takes a codeword read back from storage and returns the data. Any single flipped bit is corrected. Any two flipped bits are reported as uncorrectable. Patterns with three or more flipped bits are not guaranteed to be caught. Both halves are purely combinational.

A read codeword that is entirely zeros or entirely ones usually means a dead or unpowered storage word. Such a word may happen to decode cleanly. This block reports it as uncorrectable and raises a dedicated stuck flag. Two of the stored check bits are inverted, so no data word ever encodes to either of these patterns.

A registered sticky flag records that an uncorrectable access happened. It stays set until software clears it, so errors between polls are not lost.

Top module: `secded_codec`

## Requirements
- R1: The codeword layout is: bits [31:0] carry the data unchanged, bits [37:32] carry the six position-check bits, and bit 38 carries the overall parity. Feeding an encoder output back into the checker returns the same data with no flag raised.
- R2: For any single bit flipped among the 39, the checker returns the original data, raises the correctable flag and keeps the uncorrectable flag low.
- R3: A single flip in bits [38:32] raises the correctable flag and returns the data bits unchanged.
- R4: For any two distinct bits flipped, the uncorrectable flag is high and the correctable flag is low.
- R5: A codeword of all zeros or all ones raises the stuck flag and the uncorrectable flag, and keeps the correctable flag low.
- R6: The encoder never outputs the all-zeros or the all-ones codeword.
- R7: The correctable and uncorrectable flags are never high together.
- R8: On a rising clock edge where the read-valid input is high and the uncorrectable flag is high, the sticky flag becomes 1. Correctable or clean accesses, and uncorrectable codewords with read-valid low, leave it unchanged.
- R9: The sticky flag holds until a clock edge with the clear input high, and then becomes 0. If a set event and a clear arrive on the same edge, the set wins.
- R10: The active-low asynchronous reset forces the sticky flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the sticky flag |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 32 | Data word to encode |
| enc_code_o | output | 39 | Encoded codeword |
| dec_code_i | input | 39 | Codeword read from storage |
| dec_valid_i | input | 1 | Marks dec_code_i as a real read access |
| dec_data_o | output | 32 | Corrected data |
| dec_ce_o | output | 1 | Single error corrected |
| dec_ue_o | output | 1 | Uncorrectable error, including stuck words |
| dec_stuck_o | output | 1 | Codeword is all zeros or all ones |
| err_clr_i | input | 1 | Clears the sticky flag |
| err_sticky_o | output | 1 | Sticky uncorrectable-error flag |

## Verification
The bench walks a single flip through all 39 positions for several data words, including the check and parity bits. A decoder that mixed up data and check positions would fail this test by corrupting a data bit or missing the correction. Random double flips target a checker that reads an even-parity, nonzero syndrome as correctable; such a checker would miscorrect the data with the wrong flag. The all-zeros and all-ones words check that the stuck override wins over the ordinary decode, whose single-error result on the all-ones word would otherwise show up as correctable. The sticky flag is compared against a model on every clock, including a set and clear on the same edge and an uncorrectable word sent with read-valid low.

// File: rtl/secded_pkg.sv
package secded_pkg;
  // number of position-check bits for a data width
  function automatic int ham_bits(int dw);
    int k;
    k = 0;
    for (int i = 0; i < 16; i++)
      if ((1 << k) < dw + k + 1) k++;
    return k;
  endfunction

  // Hamming position of data bit d: the d-th non-power-of-two from 3
  function automatic int data_pos(int d);
    int n;
    int p;
    n = 0;
    p = 0;
    for (int i = 3; i < 256; i++) begin
      if (((i & (i - 1)) != 0) && (p == 0)) begin
        if (n == d) p = i;
        n++;
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/secded_pos_tab.sv
module secded_pos_tab #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = secded_pkg::ham_bits(DATA_W)
) (
  output logic [DATA_W-1:0][HAM_W-1:0] pos_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_pos
    localparam int P = secded_pkg::data_pos(g);
    assign pos_o[g] = HAM_W'(P);
  end
endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = secded_pkg::ham_bits(DATA_W),
  parameter logic [HAM_W-1:0] INV_MASK = HAM_W'(3),
  localparam int CW_W  = DATA_W + HAM_W + 1
) (
  input  logic [DATA_W-1:0][HAM_W-1:0] pos_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [CW_W-1:0]              code_o
);
  logic [HAM_W-1:0] ham;
  logic             par;

  always_comb begin
    ham = '0;
    for (int d = 0; d < DATA_W; d++)
      for (int k = 0; k < HAM_W; k++)
        if (pos_i[d][k]) ham[k] = ham[k] ^ data_i[d];
    par    = (^data_i) ^ (^ham);
    // inverted check bits keep all-0 / all-1 off the code
    code_o = {par, ham ^ INV_MASK, data_i};
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = secded_pkg::ham_bits(DATA_W),
  parameter logic [HAM_W-1:0] INV_MASK = HAM_W'(3),
  localparam int CW_W  = DATA_W + HAM_W + 1,
  localparam int MAX_POS = DATA_W + HAM_W
) (
  input  logic [DATA_W-1:0][HAM_W-1:0] pos_i,
  input  logic [CW_W-1:0]              code_i,
  output logic [DATA_W-1:0]            data_o,
  output logic                         ce_o,
  output logic                         ue_o,
  output logic                         stuck_o
);
  localparam logic [HAM_W-1:0] MAX_POS_V = HAM_W'(MAX_POS);

  logic [DATA_W-1:0] raw_d;
  logic [HAM_W-1:0]  raw_h;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              single;
  logic              dbl;
  logic              bad_syn;

  always_comb begin
    raw_d = code_i[DATA_W-1:0];
    raw_h = code_i[DATA_W +: HAM_W] ^ INV_MASK;
    syn   = raw_h;
    for (int d = 0; d < DATA_W; d++)
      for (int k = 0; k < HAM_W; k++)
        if (pos_i[d][k]) syn[k] = syn[k] ^ raw_d[d];
    odd     = (^raw_d) ^ (^raw_h) ^ code_i[CW_W-1];
    bad_syn = syn > MAX_POS_V;
    single  = odd && !bad_syn;
    dbl     = !odd && (syn != '0);
    stuck_o = (code_i == '0) || (&code_i);
    for (int d = 0; d < DATA_W; d++)
      data_o[d] = raw_d[d] ^ (single && (syn == pos_i[d]));
    ce_o = single && !stuck_o;
    ue_o = stuck_o || dbl || (odd && bad_syn);
  end
endmodule

// File: rtl/secded_sticky.sv
module secded_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = secded_pkg::ham_bits(DATA_W),
  parameter logic [HAM_W-1:0] INV_MASK = HAM_W'(3),
  localparam int CW_W  = DATA_W + HAM_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CW_W-1:0]   enc_code_o,
  input  logic [CW_W-1:0]   dec_code_i,
  input  logic              dec_valid_i,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_ce_o,
  output logic              dec_ue_o,
  output logic              dec_stuck_o,
  input  logic              err_clr_i,
  output logic              err_sticky_o
);
  logic [DATA_W-1:0][HAM_W-1:0] pos;

  secded_pos_tab #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_pos (.pos_o(pos));

  secded_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W), .INV_MASK(INV_MASK)) u_enc (
    .pos_i (pos),
    .data_i(enc_data_i),
    .code_o(enc_code_o)
  );

  secded_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W), .INV_MASK(INV_MASK)) u_dec (
    .pos_i  (pos),
    .code_i (dec_code_i),
    .data_o (dec_data_o),
    .ce_o   (dec_ce_o),
    .ue_o   (dec_ue_o),
    .stuck_o(dec_stuck_o)
  );

  secded_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dec_valid_i && dec_ue_o),
    .clr_i (err_clr_i),
    .flag_o(err_sticky_o)
  );
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DATA_W = 32,
  parameter int CW_W   = 39
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] enc_data_i,
  input logic [CW_W-1:0]   enc_code_o,
  input logic [CW_W-1:0]   dec_code_i,
  input logic              dec_valid_i,
  input logic [DATA_W-1:0] dec_data_o,
  input logic              dec_ce_o,
  input logic              dec_ue_o,
  input logic              dec_stuck_o,
  input logic              err_clr_i,
  input logic              err_sticky_o
);
  assert_roundtrip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_code_i == enc_code_o) |-> (dec_data_o == enc_data_i && !dec_ce_o && !dec_ue_o));

  assert_stuck_ue_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dec_code_i == '0) || (&dec_code_i)) |-> (dec_ue_o && !dec_ce_o));

  assert_stuck_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_stuck_o |-> dec_ue_o);

  assert_enc_not_stuck_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_code_o != '0) && !(&enc_code_o));

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_ce_o && dec_ue_o));

  assert_sticky_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_ue_o) |=> err_sticky_o);

  assert_sticky_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !(dec_valid_i && dec_ue_o)) |=> !err_sticky_o);

  assert_sticky_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_sticky_o && !err_clr_i) |=> err_sticky_o);
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .CW_W(CW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enc_data_i  (enc_data_i),
  .enc_code_o  (enc_code_o),
  .dec_code_i  (dec_code_i),
  .dec_valid_i (dec_valid_i),
  .dec_data_o  (dec_data_o),
  .dec_ce_o    (dec_ce_o),
  .dec_ue_o    (dec_ue_o),
  .dec_stuck_o (dec_stuck_o),
  .err_clr_i   (err_clr_i),
  .err_sticky_o(err_sticky_o)
);

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
module tb_secded_codec;
  logic        clk;
  logic        rst_n;
  logic [31:0] enc_d;
  logic [38:0] enc_c;
  logic [38:0] dec_c;
  logic        dec_v;
  logic [31:0] dec_d;
  logic        ce, ue, st;
  logic        clr;
  logic        sticky;

  int total = 0;
  int bad   = 0;
  bit running = 1'b0;

  logic m_sticky;
  logic m_set, m_clr;

  secded_codec dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_data_i(enc_d), .enc_code_o(enc_c),
    .dec_code_i(dec_c), .dec_valid_i(dec_v),
    .dec_data_o(dec_d), .dec_ce_o(ce), .dec_ue_o(ue), .dec_stuck_o(st),
    .err_clr_i(clr), .err_sticky_o(sticky)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference sticky model, R8 R9 R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)     m_sticky <= 1'b0;
    else if (m_set) m_sticky <= 1'b1;
    else if (m_clr) m_sticky <= 1'b0;
  end

  always @(negedge clk)
    if (running) check(sticky === m_sticky, "R8/R9", "sticky vs model", 64'(sticky), 64'(m_sticky));

  task automatic encode(input logic [31:0] d, output logic [38:0] c);
    @(negedge clk);
    enc_d = d;
    #1;
    c = enc_c;
    check(c[31:0] === d, "R1", "data field", 64'(c[31:0]), 64'(d));
    check(c != '0 && c != '1, "R6", "encoder stuck word", 64'(c), 64'(0));
  endtask

  // kind: 0 clean, 1 single, 2 double
  task automatic apply(input logic [38:0] c, input logic v, input logic cl,
                       input logic [31:0] d, input int kind, input string req);
    bit   stk;
    logic e_ce, e_ue;
    stk  = (c == '0) || (c == '1);
    e_ce = (kind == 1) && !stk;
    e_ue = (kind == 2) || stk;
    @(negedge clk);
    dec_c = c; dec_v = v; clr = cl;
    m_set = v && e_ue;
    m_clr = cl;
    #1;
    check(ce === e_ce, req, "ce", 64'(ce), 64'(e_ce));
    check(ue === e_ue, req, "ue", 64'(ue), 64'(e_ue));
    check(st === stk, "R5", "stuck", 64'(st), 64'(stk));
    check(!(ce && ue), "R7", "ce and ue", 64'({ce, ue}), 64'(0));
    if (kind < 2 && !stk)
      check(dec_d === d, req, "data", 64'(dec_d), 64'(d));
  endtask

  initial begin
    #(50000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [38:0] code;
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h0000_0001;
    pats[4] = 32'h8000_0000; pats[5] = 32'h1234_5678;
    pats[6] = $urandom;      pats[7] = $urandom;
    rst_n = 1'b0; enc_d = '0; dec_c = 39'h1; dec_v = 1'b0; clr = 1'b0;
    m_set = 1'b0; m_clr = 1'b0;
    running = 1'b1;
    #12;
    check(sticky === 1'b0, "R10", "sticky in reset", 64'(sticky), 64'(0));
    @(negedge clk); rst_n = 1'b1;

    for (int p = 0; p < 8; p++) begin
      encode(pats[p], code);
      apply(code, 1'b1, 1'b0, pats[p], 0, "R1");
      for (int i = 0; i < 39; i++)
        apply(code ^ (39'h1 << i), 1'b1, 1'b0, pats[p], 1, (i >= 32) ? "R3" : "R2");
      for (int j = 0; j < 16; j++) begin
        int a, b;
        a = $urandom % 39;
        b = (a + 1 + ($urandom % 38)) % 39;
        apply(code ^ (39'h1 << a) ^ (39'h1 << b), 1'b1, 1'b0, pats[p], 2, "R4");
      end
      apply(code, 1'b1, 1'b1, pats[p], 0, "R9");
      apply(code, 1'b1, 1'b0, pats[p], 0, "R9");
    end

    // R5 stuck words, with and without valid
    encode(32'hDEAD_BEEF, code);
    apply('0, 1'b0, 1'b0, 32'h0, 2, "R5");
    apply('1, 1'b0, 1'b0, 32'h0, 2, "R8");
    apply(code, 1'b1, 1'b0, 32'hDEAD_BEEF, 0, "R8");
    apply('1, 1'b1, 1'b0, 32'h0, 2, "R5");
    for (int i = 0; i < 4; i++)
      apply(code ^ 39'h1, 1'b1, 1'b0, 32'hDEAD_BEEF, 1, "R9");
    // R9 set and clear on the same edge
    apply('0, 1'b1, 1'b1, 32'h0, 2, "R9");
    apply(code, 1'b1, 1'b1, 32'hDEAD_BEEF, 0, "R9");
    apply(code, 1'b0, 1'b0, 32'hDEAD_BEEF, 0, "R9");
    apply(code ^ 39'h3, 1'b1, 1'b0, 32'hDEAD_BEEF, 2, "R8");
    // R10 asynchronous reset mid-run
    @(negedge clk); dec_v = 1'b0; m_set = 1'b0; m_clr = 1'b0;
    #1 rst_n = 1'b0;
    #1 check(sticky === 1'b0, "R10", "sticky after reset", 64'(sticky), 64'(0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule